// File: doc/BRIEF.md
# Four-Wire Serial Configuration Register Port

This block is the slave end of a four-wire control link: an active-low select, a serial clock, serial data in and serial data out with its own output enable. Through it an external host reads and writes a bank of 32 eight-bit configuration registers. Every transfer is a 16-bit frame. The host sends a 2-bit chip address first, then a read/write flag, then a 5-bit register address MSB first, and last a data byte MSB first. A write reaches the bank only when the chip address matches and the frame is exactly 16 clock pulses long. On a read, the addressed register is shifted back in the slots where a write would carry its data byte.

The serial pins are oversampled by the system clock `clk`. Each pin passes through a two-stage synchronizer, and serial clock edges are found by comparing successive samples. The active-low power-down input is synchronized in the same way and then acts as a synchronous active-high reset. That reset returns every register to its default and clears the frame logic. The whole bank is also driven out on a flat bus, so the surrounding logic can use the register contents directly.

Top module: `serctl_port`

## Requirements
- R1: A frame is sent MSB first as bits {chip[1:0], rw, addr[4:0], data[7:0]}. With chip = 2'b00 and rw = 1, `data` is written to register `addr` when `csn` rises after exactly 16 rising edges of `sclk`. No other register changes.
- R2: A write frame ended after 15 or fewer rising `sclk` edges changes no register.
- R3: A write frame that keeps going to 17 or more rising `sclk` edges changes no register.
- R4: A frame whose chip field is not 2'b00 is ignored. A write changes no register, and a read never raises `sdo_oe`.
- R5: With chip = 2'b00 and rw = 0, the addressed register appears on `sdo` MSB first. Each bit is changed after a falling `sclk` edge, and bit 7-k is valid before rising edge number 9+k (k = 0..7).
- R6: `sdo_oe` is low while `csn` is high, during the 8 header bits, and for the whole of any write frame. It drops after `csn` returns high.
- R7: While `pdn_n` is low, every register goes back to its default. Register i has the default ((i*17) mod 256) XOR 8'hA5.
- R8: `regs_o[8*i +: 8]` always shows register i. After power-down it shows the defaults given in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| pdn_n | input | 1 | Active-low power-down; restores register defaults |
| csn | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| regs_o | output | 256 | All 32 registers, register i at bits 8*i+7..8*i |

## Verification
Some properties are checked on every clock cycle. The output enable drops after select goes high and is never raised unless a read is active. A write strobe never coincides with a driven output. The bank holds its contents whenever no write strobe is present, and it matches the defaults one cycle after a power-down cycle. Other behaviour only the directed scenarios can show: that a write lands only for a frame of exactly sixteen pulses, that a wrong chip field is ignored, that read bits appear MSB first in the right slots, and that the defaults come back after power-down.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int NREG       = 32;
  localparam int DW         = 8;
  localparam int AW         = $clog2(NREG);
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 8;
  localparam logic [1:0] CHIP_ID = 2'b00;

  // Default register image: register i holds ((i*17) mod 256) ^ 8'hA5.
  function automatic logic [NREG*DW-1:0] default_image();
    logic [NREG*DW-1:0] img;
    img = '0;
    for (int i = 0; i < NREG; i++) begin
      img[i*DW +: DW] = DW'(i * 17) ^ DW'(8'hA5);
    end
    return img;
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int AW   = $clog2(NREG),
  parameter logic [NREG*DW-1:0] INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] image_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= INIT[i*DW +: DW];
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    assign image_o[g*DW +: DW] = mem[g];
  end

  AST_PD_DEFAULT: assert property (@(posedge clk) rst |=> (image_o == INIT)); // R7
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(image_o)); // R2
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame #(
  parameter int DW         = 8,
  parameter int AW         = 5,
  parameter int FRAME_BITS = 16,
  parameter int HDR_BITS   = 8,
  parameter logic [1:0] CHIP_ID = 2'b00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_q,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_q,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] CNT_HDR1 = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] CNT_HDR  = CW'(HDR_BITS);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic [CW-1:0]       cnt;
  logic [DW-1:0]       shin;
  logic [HDR_BITS-1:0] hdr;
  logic [DW-1:0]       shout;
  logic                load_pend;
  logic                rd_active;
  logic                csn_d;

  wire       csn_rise = csn_q & ~csn_d;
  wire [1:0] hdr_chip = hdr[HDR_BITS-1 -: 2];
  wire       hdr_rw   = hdr[AW];

  always_ff @(posedge clk) begin
    if (rst) csn_d <= 1'b1;
    else     csn_d <= csn_q;
  end

  always_ff @(posedge clk) begin
    if (rst || csn_q) begin
      cnt       <= '0;
      shin      <= '0;
      load_pend <= 1'b0;
      rd_active <= 1'b0;
      shout     <= '0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
      if (rst) hdr <= '0;
      else if (!csn_rise) hdr <= '0;
    end else begin
      load_pend <= sclk_rise && (cnt == CNT_HDR1);
      if (sclk_rise) begin
        shin <= {shin[DW-2:0], sdi_q};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_HDR1) hdr <= {shin[HDR_BITS-2:0], sdi_q};
      end
      if (load_pend && hdr_chip == CHIP_ID && !hdr_rw) begin
        rd_active <= 1'b1;
        shout     <= rd_data;
      end
      if (sclk_fall && rd_active && cnt >= CNT_HDR && cnt < CNT_FULL) begin
        sdo_o    <= shout[DW-1];
        shout    <= {shout[DW-2:0], 1'b0};
        sdo_oe_o <= 1'b1;
      end
    end
  end

  assign reg_addr = hdr[AW-1:0];
  assign wr_data  = shin;
  assign wr_en    = csn_rise && (cnt == CNT_FULL) && (hdr_chip == CHIP_ID) && hdr_rw;

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    csn_q |=> !sdo_oe_o); // R6
  AST_OE_RDONLY: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> rd_active); // R5
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !sdo_oe_o); // R6
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int NREG_P = NREG,
  parameter int DW_P   = DW,
  parameter logic [NREG_P*DW_P-1:0] DEFAULTS = default_image()
) (
  input  logic                   clk,
  input  logic                   pdn_n,
  input  logic                   csn,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [NREG_P*DW_P-1:0] regs_o
);
  localparam int AW_P = $clog2(NREG_P);

  logic [3:0]      pins_q;
  logic            rst;
  logic            csn_q, sclk_q, sdi_q, sclk_d;
  logic            wr_en;
  logic [AW_P-1:0] reg_addr;
  logic [DW_P-1:0] wr_data, rd_data;

  serctl_sync #(.W(4), .STAGES(2)) u_sync (
    .clk (clk),
    .d_i ({pdn_n, csn, sclk, sdi}),
    .q_o (pins_q)
  );

  assign rst    = ~pins_q[3];
  assign csn_q  = pins_q[2];
  assign sclk_q = pins_q[1];
  assign sdi_q  = pins_q[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_q;
  end

  serctl_frame #(
    .DW(DW_P), .AW(AW_P), .FRAME_BITS(FRAME_BITS),
    .HDR_BITS(HDR_BITS), .CHIP_ID(CHIP_ID)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .csn_q     (csn_q),
    .sclk_rise (sclk_q & ~sclk_d),
    .sclk_fall (~sclk_q & sclk_d),
    .sdi_q     (sdi_q),
    .rd_data   (rd_data),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe)
  );

  serctl_regbank #(.NREG(NREG_P), .DW(DW_P), .AW(AW_P), .INIT(DEFAULTS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (reg_addr),
    .wdata   (wr_data),
    .raddr   (reg_addr),
    .rdata   (rd_data),
    .image_o (regs_o)
  );
endmodule

// File: tb/serctl_port_tb.sv
module serctl_port_tb;
  localparam int HALF = 8;
  logic clk = 1'b0, pdn_n = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [255:0] regs;
  logic [7:0] model [32];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serctl_port u_dut (.clk(clk), .pdn_n(pdn_n), .csn(csn), .sclk(sclk), .sdi(sdi),
                     .sdo(sdo), .sdo_oe(sdo_oe), .regs_o(regs));

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 17) % 256) ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 32; i++) chk(req, $sformatf("reg %0d", i), 32'(regs[i*8 +: 8]), 32'(model[i]));
  endtask

  // Sends n clock pulses of frame f; returns captured read byte and oe observations.
  task automatic xfer(input logic [15:0] f, input int n, output logic [7:0] rd,
                      output int oe_hdr, output int oe_data);
    rd = '0; oe_hdr = 0; oe_data = 0;
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 8 && sdo_oe) oe_hdr++;
      if (i >= 8 && i < 16) begin
        rd[15-i] = sdo;
        if (sdo_oe) oe_data++;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [15:0] frm(input logic [1:0] chip, input logic rw,
                                      input logic [4:0] a, input logic [7:0] d);
    return {chip, rw, a, d};
  endfunction

  task automatic t_reset();
    for (int i = 0; i < 32; i++) model[i] = dflt(i);
    chk_bank("R8");
    chk("R6", "oe idle after reset", 32'(sdo_oe), 32'd0);
  endtask

  task automatic t_write();
    logic [7:0] rd; int oh, od;
    xfer(frm(2'b00, 1'b1, 5'd5, 8'h3C), 16, rd, oh, od);
    model[5] = 8'h3C;
    chk_bank("R1");
    chk("R6", "oe during write frame", 32'(oh + od), 32'd0);
    chk("R6", "oe after write", 32'(sdo_oe), 32'd0);
    xfer(frm(2'b00, 1'b1, 5'd31, 8'hFF), 16, rd, oh, od);
    model[31] = 8'hFF;
    xfer(frm(2'b00, 1'b1, 5'd0, 8'h00), 16, rd, oh, od);
    model[0] = 8'h00;
    chk_bank("R1");
  endtask

  task automatic t_bad_length();
    logic [7:0] rd; int oh, od;
    xfer(frm(2'b00, 1'b1, 5'd7, 8'h5A), 15, rd, oh, od);
    chk_bank("R2");
    xfer(frm(2'b00, 1'b1, 5'd7, 8'h5A), 8, rd, oh, od);
    chk_bank("R2");
    xfer(frm(2'b00, 1'b1, 5'd7, 8'h5A), 17, rd, oh, od);
    chk_bank("R3");
    xfer(frm(2'b00, 1'b1, 5'd7, 8'h5A), 24, rd, oh, od);
    chk_bank("R3");
  endtask

  task automatic t_chip();
    logic [7:0] rd; int oh, od;
    xfer(frm(2'b01, 1'b1, 5'd9, 8'h81), 16, rd, oh, od);
    chk_bank("R4");
    xfer(frm(2'b10, 1'b1, 5'd9, 8'h81), 16, rd, oh, od);
    chk_bank("R4");
    xfer(frm(2'b11, 1'b0, 5'd5, 8'h00), 16, rd, oh, od);
    chk("R4", "oe on foreign read", 32'(oh + od), 32'd0);
  endtask

  task automatic t_read();
    logic [7:0] rd; int oh, od;
    xfer(frm(2'b00, 1'b0, 5'd5, 8'h00), 16, rd, oh, od);
    chk("R5", "read reg 5", 32'(rd), 32'(model[5]));
    chk("R6", "oe in header", 32'(oh), 32'd0);
    chk("R5", "oe in data slots", 32'(od), 32'd8);
    chk("R6", "oe after read", 32'(sdo_oe), 32'd0);
    xfer(frm(2'b00, 1'b0, 5'd31, 8'h00), 16, rd, oh, od);
    chk("R5", "read reg 31", 32'(rd), 32'(model[31]));
    xfer(frm(2'b00, 1'b0, 5'd18, 8'h00), 16, rd, oh, od);
    chk("R5", "read reg 18 default", 32'(rd), 32'(dflt(18)));
    chk_bank("R5");
  endtask

  task automatic t_powerdown();
    pdn_n = 1'b0;
    repeat (6) @(negedge clk);
    pdn_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 32; i++) model[i] = dflt(i);
    chk_bank("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (8) @(negedge clk);
    pdn_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_write();
    t_bad_length();
    t_chip();
    t_read();
    t_powerdown();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule